// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Control Port

This block is the digital front of an eight-input successive-approximation converter. A host clocks an 8-bit command into `din` on rising edges of `sclk` while `cs_n` is low. The command selects an input (or an input pair), picks single-ended or differential measurement, and sets the power and conversion-clock behaviour. The block raises `busy` and then returns a 16-bit result on `dout`, most significant bit first, with one bit on each falling edge of `sclk`. All serial pins are brought into the `clk` domain through synchronisers. The block works on edges detected there, so `sclk` must be much slower than `clk`.

The result word comes from a parallel stream input (`smp_data`, `smp_valid`, `smp_ready`) that stands in for the comparator. `smp_ready` rises when a command completes and stays high until one word is accepted, on a cycle with `smp_valid` and `smp_ready` both high. A source may hold `smp_valid` low and so stall the handshake. It must still deliver the word before the first result bit is due. In external-clock mode that is the second falling edge after the command. In internal-clock mode it is the first falling edge after `busy` drops.

The port keeps a clock-mode register and a sleep flag. In internal-clock mode, a timer of `INT_CONV_CYCLES` clock cycles replaces the serial clock while the conversion runs. Any command that changes the clock mode affects only the conversion that follows it.

Top module: `sadc_serial_port`

## Requirements
- R1: A command begins at the first `sclk` rise that samples `din`=1 while `cs_n` is low and the port is listening. Earlier zeros are ignored. The seven following rises deliver, in order: input code bit 2, bit 1, bit 0, an ignored bit, the single-ended flag, mode bit 1, mode bit 0.
- R2: With the single-ended flag at 1, input code 000..111 selects input 0,2,4,6,1,3,5,7 respectively (so 100 selects input 1). `mux_pos` then carries that input and `mux_neg_com` is 1.
- R3: With the single-ended flag at 0, code bits 1..0 select the pair (2k, 2k+1) and `mux_neg_com` is 0. Code bit 2 at 0 makes the even input positive (`mux_pos`=2k, `mux_neg`=2k+1). Code bit 2 at 1 swaps them.
- R4: In external-clock mode, `busy` rises at the first `sclk` fall after the command and falls at the next `sclk` fall.
- R5: The result is shifted out MSB first, one bit per `sclk` fall, and `dout_oe` is high. Bit 15 appears on the fall that ends `busy` in external-clock mode, or on the first fall after `busy` drops in internal-clock mode. After bit 0, `dout` drives 0.
- R6: In internal-clock mode, `busy` rises right after the command and falls after `INT_CONV_CYCLES` clock cycles, with no `sclk` edge needed.
- R7: Mode bits 11 select external clocking and keep the port awake. Mode bits 10 select internal clocking and keep the port awake. The command's own conversion uses the clock mode held before the command, and `int_clk_mode` shows the held mode.
- R8: Mode bits 00 keep the held clock mode and set sleep between conversions. While sleeping, `pwr_up` is 0 when idle. It goes to 1 from the command's completion to the end of the result, and that result is valid.
- R9: Mode bits 01 change neither the held clock mode nor the sleep flag.
- R10: `cs_n` high abandons any command or transfer. `busy` and `dout_oe` go to 0, and a partial command changes no state.
- R11: After reset: external-clock mode, awake (`pwr_up`=1), `busy`=0, `dout_oe`=0, `smp_ready`=0, `mux_neg_com`=1.
- R12: `smp_ready` is high from command completion until one word is accepted, and it falls on the cycle after acceptance. The accepted word is the one shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; high aborts |
| din | input | 1 | Serial command data |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` (0 = high impedance) |
| busy | output | 1 | Conversion in progress |
| smp_data | input | RES_BITS | Parallel conversion word |
| smp_valid | input | 1 | `smp_data` is valid |
| smp_ready | output | 1 | Port is waiting for a word |
| mux_pos | output | 3 | Positive input selection |
| mux_neg | output | 3 | Negative input selection (differential) |
| mux_neg_com | output | 1 | Negative input is the common pin |
| pwr_up | output | 1 | Converter powered |
| int_clk_mode | output | 1 | Held clock mode: 1 internal, 0 external |

## Verification
The assertions assume that every phase of `sclk` spans several `clk` cycles, so that each synchronised edge is seen exactly once. They also assume that `din` is settled before the rise that samples it, and that a word is accepted before the first result bit is loaded. The bench keeps each `sclk` phase at eight clock cycles and changes `din` four cycles before a rise. It holds `smp_valid` high, except in one internal-clock case, where it raises it well inside the busy window.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    ST_LISTEN, ST_ARM, ST_EXT_BUSY, ST_INT_CONV, ST_READY, ST_SHIFT
  } sadc_state_e;

  typedef struct packed {
    logic [2:0] code;
    logic       single;
    logic [1:0] pd;
  } sadc_cmd_t;

  localparam logic [1:0] PD_SLEEP  = 2'b00;
  localparam logic [1:0] PD_RSVD   = 2'b01;
  localparam logic [1:0] PD_INTCLK = 2'b10;
  localparam logic [1:0] PD_EXTCLK = 2'b11;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pipe[0] <= RESET_VAL;
    else        pipe[0] <= d;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pipe[i] <= RESET_VAL;
      else        pipe[i] <= pipe[i-1];
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sadc_cmd_shift.sv
module sadc_cmd_shift
  import sadc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      abort,
  input  logic      en,
  input  logic      bit_in,
  output logic      done,
  output sadc_cmd_t cmd
);
  localparam int PAYLOAD = 7;
  localparam int CNT_W = $clog2(PAYLOAD);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [PAYLOAD-2:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      sr     <= '0;
      done   <= 1'b0;
      cmd    <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (en) begin
        if (!active) begin
          if (bit_in) begin
            active <= 1'b1;
            cnt    <= '0;
          end
        end else begin
          sr  <= {sr[PAYLOAD-3:0], bit_in};
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(PAYLOAD-1)) begin
            active     <= 1'b0;
            done       <= 1'b1;
            cmd.code   <= sr[5:3];
            cmd.single <= sr[1];
            cmd.pd     <= {sr[0], bit_in};
          end
        end
      end
    end
  end

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !done);
endmodule

// File: rtl/sadc_out_shift.sv
module sadc_out_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] data,
  output logic         dout
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= data;
    else if (shift) sr <= {sr[W-2:0], 1'b0};

  assign dout = sr[W-1];

  a_r5_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> dout == $past(data[W-1]));
endmodule

// File: rtl/sadc_serial_port.sv
module sadc_serial_port
  import sadc_pkg::*;
#(
  parameter int RES_BITS = 16,
  parameter int INT_CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                din,
  output logic                dout,
  output logic                dout_oe,
  output logic                busy,
  input  logic [RES_BITS-1:0] smp_data,
  input  logic                smp_valid,
  output logic                smp_ready,
  output logic [2:0]          mux_pos,
  output logic [2:0]          mux_neg,
  output logic                mux_neg_com,
  output logic                pwr_up,
  output logic                int_clk_mode
);
  localparam int BIT_W = $clog2(RES_BITS);
  localparam int TMR_W = $clog2(INT_CONV_CYCLES + 1);

  logic cs_s, sclk_s, din_s, sclk_q;
  logic rise, fall;
  sadc_state_e st;
  logic cmd_done;
  sadc_cmd_t cmd;
  logic mode_int, sleep_q, have_smp;
  logic [RES_BITS-1:0] smp_word;
  logic [TMR_W-1:0] tmr;
  logic [BIT_W-1:0] bitcnt;
  logic out_load, out_shift, waiting;

  sadc_sync #(.W(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, din}), .q({cs_s, sclk_s, din_s}));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;

  sadc_cmd_shift u_cmd (
    .clk(clk), .rst_n(rst_n), .abort(cs_s),
    .en(rise & ~cs_s & (st == ST_LISTEN)), .bit_in(din_s),
    .done(cmd_done), .cmd(cmd));

  assign out_load  = ~cs_s & fall & ((st == ST_EXT_BUSY) | (st == ST_READY));
  assign out_shift = ~cs_s & fall & (st == ST_SHIFT);
  assign waiting   = (st == ST_ARM) | (st == ST_EXT_BUSY) |
                     (st == ST_INT_CONV) | (st == ST_READY);

  sadc_out_shift #(.W(RES_BITS)) u_out (
    .clk(clk), .rst_n(rst_n), .load(out_load), .shift(out_shift),
    .data(smp_word), .dout(dout));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_LISTEN;
      busy        <= 1'b0;
      dout_oe     <= 1'b0;
      mode_int    <= 1'b0;
      sleep_q     <= 1'b0;
      mux_pos     <= '0;
      mux_neg     <= '0;
      mux_neg_com <= 1'b1;
      have_smp    <= 1'b0;
      smp_word    <= '0;
      tmr         <= '0;
      bitcnt      <= '0;
    end else if (cs_s) begin
      st      <= ST_LISTEN;
      busy    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      if (smp_valid && smp_ready) begin
        smp_word <= smp_data;
        have_smp <= 1'b1;
      end
      unique case (st)
        ST_LISTEN: if (cmd_done) begin
          mux_pos     <= {cmd.code[1:0], cmd.code[2]};
          mux_neg     <= {cmd.code[1:0], ~cmd.code[2]};
          mux_neg_com <= cmd.single;
          have_smp    <= 1'b0;
          unique case (cmd.pd)
            PD_EXTCLK: begin mode_int <= 1'b0; sleep_q <= 1'b0; end
            PD_INTCLK: begin mode_int <= 1'b1; sleep_q <= 1'b0; end
            PD_SLEEP:  sleep_q <= 1'b1;
            default:   ;
          endcase
          if (mode_int) begin
            st   <= ST_INT_CONV;
            busy <= 1'b1;
            tmr  <= '0;
          end else begin
            st <= ST_ARM;
          end
        end
        ST_ARM: if (fall) begin
          busy <= 1'b1;
          st   <= ST_EXT_BUSY;
        end
        ST_EXT_BUSY: if (fall) begin
          busy    <= 1'b0;
          dout_oe <= 1'b1;
          bitcnt  <= BIT_W'(RES_BITS - 1);
          st      <= ST_SHIFT;
        end
        ST_INT_CONV: begin
          tmr <= tmr + 1'b1;
          if (tmr == TMR_W'(INT_CONV_CYCLES - 1)) begin
            busy <= 1'b0;
            st   <= ST_READY;
          end
        end
        ST_READY: if (fall) begin
          dout_oe <= 1'b1;
          bitcnt  <= BIT_W'(RES_BITS - 1);
          st      <= ST_SHIFT;
        end
        ST_SHIFT: if (fall) begin
          if (bitcnt == '0) st <= ST_LISTEN;
          else              bitcnt <= bitcnt - 1'b1;
        end
        default: st <= ST_LISTEN;
      endcase
    end
  end

  assign smp_ready    = waiting & ~have_smp;
  assign pwr_up       = ~sleep_q | (st != ST_LISTEN);
  assign int_clk_mode = mode_int;

  a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!busy && !dout_oe));
  a_r8_awake_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pwr_up);
  a_r12_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);
  a_r12_word_in_time: assert property (@(posedge clk) disable iff (!rst_n)
    out_load |-> have_smp);
  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_done |=> $stable(mode_int));
  a_r9_reserved_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !cs_s && cmd.pd == PD_RSVD) |=> ($stable(mode_int) && $stable(sleep_q)));
  a_r4_one_period: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXT_BUSY && fall && !cs_s) |=> !busy);
  a_r5_drive_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    out_load |=> dout_oe);
endmodule

// File: tb/sadc_serial_port_bench.sv
module sadc_serial_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic dout, dout_oe, busy, smp_ready, mux_neg_com, pwr_up, int_clk_mode;
  logic [15:0] smp_data = '0;
  logic smp_valid = 1'b1;
  logic [2:0] mux_pos, mux_neg;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  logic [15:0] got_word;
  event word_ev;
  bit done_flag = 0;

  always #4 clk = ~clk;

  sadc_serial_port u_sadc_serial_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .busy(busy),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .mux_pos(mux_pos), .mux_neg(mux_neg), .mux_neg_com(mux_neg_com),
    .pwr_up(pwr_up), .int_clk_mode(int_clk_mode));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one sclk period: din set, rise, sample in high phase, fall
  task automatic cyc(input logic b, output logic [2:0] s);
    din = b; tick(4);
    sclk = 1'b1; tick(4);
    s = {dout_oe, busy, dout};
    tick(4);
    sclk = 1'b0; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] byt, input int nz);
    logic [2:0] s;
    for (int i = 0; i < nz; i++) cyc(1'b0, s);
    for (int i = 7; i >= 0; i--) cyc(byt[i], s);
  endtask

  task automatic conv(input logic [2:0] code, input logic sgl, input logic [1:0] pd,
                      input logic exp_int, input logic [15:0] word, input logic late,
                      input logic pwr_after, input logic mode_after, input int nz);
    logic [2:0] s;
    logic [15:0] w;
    int se_map [8] = '{0, 2, 4, 6, 1, 3, 5, 7};
    int pos, neg;
    smp_data = word;
    smp_valid = !late;
    exp_q.push_back(word);
    send_byte({1'b1, code, 1'b0, sgl, pd}, nz);
    if (sgl) begin
      pos = se_map[code];
      chk(mux_pos == 3'(pos), "R2 single-ended input", mux_pos, pos);
      chk(mux_neg_com == 1'b1, "R2 common negative", mux_neg_com, 1);
    end else begin
      pos = 2 * code[1:0] + code[2];
      neg = 2 * code[1:0] + (1 - code[2]);
      chk(mux_pos == 3'(pos), "R3 differential positive", mux_pos, pos);
      chk(mux_neg == 3'(neg), "R3 differential negative", mux_neg, neg);
      chk(mux_neg_com == 1'b0, "R3 no common", mux_neg_com, 0);
    end
    chk(pwr_up == 1'b1, "R8 awake during conversion", pwr_up, 1);
    if (exp_int) begin
      chk(busy == 1'b1, "R6 busy after command", busy, 1);
      if (late) begin
        chk(smp_ready == 1'b1, "R12 ready while waiting", smp_ready, 1);
        smp_valid = 1'b1; tick(2);
        chk(smp_ready == 1'b0, "R12 ready drops", smp_ready, 0);
      end
      tick(60);
      chk(busy == 1'b0, "R6 busy ends without sclk", busy, 0);
      cyc(1'b0, s);
      chk(s[1] == 1'b0, "R6 busy stays low", s[1], 0);
    end else begin
      cyc(1'b0, s);
      chk(s[1] == 1'b1, "R4 busy for one period", s[1], 1);
    end
    for (int i = 15; i >= 0; i--) begin
      cyc(1'b0, s);
      w[i] = s[0];
      if (i == 15) begin
        chk(s[2] == 1'b1, "R5 output enabled", s[2], 1);
        chk(s[1] == 1'b0, "R4 busy ends at MSB", s[1], 0);
      end
    end
    got_word = w;
    -> word_ev;
    tick(4);
    chk(dout == 1'b0, "R5 zero after LSB", dout, 0);
    chk(pwr_up == pwr_after, "R8 power state after", pwr_up, pwr_after);
    chk(int_clk_mode == mode_after, "R7 held clock mode", int_clk_mode, mode_after);
  endtask

  // scoreboard monitor
  initial forever begin
    logic [15:0] e;
    @(word_ev);
    if (exp_q.size() == 0) begin
      chk(1'b0, "R5 unexpected word", got_word, 0);
    end else begin
      e = exp_q.pop_front();
      chk(got_word == e, "R5 R12 result word", got_word, e);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] s;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    chk(busy == 1'b0, "R11 busy", busy, 0);
    chk(dout_oe == 1'b0, "R11 oe", dout_oe, 0);
    chk(int_clk_mode == 1'b0, "R11 external mode", int_clk_mode, 0);
    chk(pwr_up == 1'b1, "R11 awake", pwr_up, 1);
    chk(mux_neg_com == 1'b1, "R11 common", mux_neg_com, 1);
    chk(smp_ready == 1'b0, "R11 ready", smp_ready, 0);
    cs_n = 1'b0; tick(8);

    // R1 leading zeros, R2 code 100 -> input 1
    conv(3'b100, 1'b1, 2'b11, 1'b0, 16'hA5C3, 1'b0, 1'b1, 1'b0, 3);
    // R3, R7 request internal; this conversion still external
    conv(3'b011, 1'b0, 2'b10, 1'b0, 16'h0001, 1'b0, 1'b1, 1'b1, 0);
    // R6 internal, R12 late word
    conv(3'b110, 1'b0, 2'b10, 1'b1, 16'h8000, 1'b1, 1'b1, 1'b1, 1);
    // R9 reserved code keeps mode and power
    conv(3'b111, 1'b1, 2'b01, 1'b1, 16'h7FFE, 1'b0, 1'b1, 1'b1, 0);
    // R8 sleep keeps internal mode
    conv(3'b010, 1'b1, 2'b00, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b1, 0);
    chk(pwr_up == 1'b0, "R8 asleep when idle", pwr_up, 0);
    conv(3'b101, 1'b0, 2'b00, 1'b1, 16'hBEEF, 1'b0, 1'b0, 1'b1, 2);
    conv(3'b001, 1'b1, 2'b11, 1'b1, 16'h5A5A, 1'b0, 1'b1, 1'b0, 0);
    conv(3'b000, 1'b1, 2'b11, 1'b0, 16'hFFFF, 1'b0, 1'b1, 1'b0, 0);

    // R10 partial command aborted
    for (int i = 0; i < 6; i++) cyc((i == 0 || i == 6) ? 1'b1 : 1'b0, s);
    cyc(1'b1, s);
    cs_n = 1'b1; tick(8);
    chk(dout_oe == 1'b0, "R10 oe off after abort", dout_oe, 0);
    chk(busy == 1'b0, "R10 busy off after abort", busy, 0);
    chk(int_clk_mode == 1'b0, "R10 partial has no effect", int_clk_mode, 0);
    cs_n = 1'b0; tick(8);
    conv(3'b001, 1'b0, 2'b11, 1'b0, 16'h0F0F, 1'b0, 1'b1, 1'b0, 0);

    // R10 abort during busy
    send_byte(8'b1_001_0_0_11, 0);
    cyc(1'b0, s);
    chk(s[1] == 1'b1, "R10 busy before abort", s[1], 1);
    cs_n = 1'b1; tick(8);
    chk(busy == 1'b0, "R10 busy cleared", busy, 0);
    chk(dout_oe == 1'b0, "R10 oe cleared", dout_oe, 0);
    cs_n = 1'b0; tick(8);
    conv(3'b110, 1'b1, 2'b11, 1'b0, 16'hC001, 1'b0, 1'b1, 1'b0, 0);

    tick(4);
    chk(exp_q.size() == 0, "R5 all words seen", exp_q.size(), 0);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule